// File: doc/BRIEF.md
# Memory Instruction Pipeline with Store-Buffer Gating

This block models the timing of memory instructions in a small in-order pipeline. Each instruction is a load or a store. It is taken into an entry slot, then moves into one shared memory stage. From there it forks by kind: a load goes to a load slot that counts down a per-instruction latency, and a store goes to a store slot. Both slots then retire the instruction, which is shown by a one-cycle retire pulse.

A store leaving the store slot places an entry in a store buffer. The block tracks only the fill level of that buffer, as one of three states. The buffer drains one entry per cycle while the load slot is empty, because a load holds the memory bus for as long as it sits in the load slot. A bus-free flag, high only when the buffer is empty and the store slot is vacant, decides when a load may start its memory access. Data, addresses and caches are not modelled. The block is meant for checking scheduling and ordering rules, and for driving the occupancy views of a larger pipeline model.

Top module: `memq_pipe`

## Requirements
- R1: While reset is asserted and at the first falling edge after it, every slot is empty, `ld_remain` is 0, `sb_state` is 0 (empty), `bus_free` and `in_ready` are 1, and both retire pulses are 0.
- R2: An instruction is taken when `in_valid` and `in_ready` are both high at a rising edge. It occupies the entry slot after that edge and moves to the shared stage at the next edge on which the shared stage is empty or emptying. Each slot holds at most one instruction.
- R3: From the shared stage, an instruction with `in_is_store`=0 (load) can only enter the load slot, and an instruction with `in_is_store`=1 (store) can only enter the store slot.
- R4: A load enters the load slot with `ld_remain` equal to its `in_lat`. The count drops by 1 at each edge while it is nonzero. The load leaves at the edge after the count reads 0, so it stays in the slot for `in_lat`+1 cycles. `done_ld` is high for the one cycle after that edge.
- R5: A store spends one cycle in the store slot unless the buffer is full and not draining. When it leaves, it adds one buffer entry and raises `done_st` for one cycle.
- R6: `sb_state` encodes the buffer fill level as 0 = empty, 1 = partly filled, 2 = full (holding SB_DEPTH entries). The value 3 never appears.
- R7: `bus_free` is 1 exactly when `sb_state` is empty and the store slot is vacant.
- R8: A load in the shared stage moves on only at an edge where `bus_free` is 1 and the load slot is empty or emptying. Otherwise it stalls.
- R9: The buffer loses one entry per edge while it is non-empty and the load slot is empty. It loses no entry while a load sits in the load slot.
- R10: A store in the shared stage stalls while `sb_state` is full.
- R11: `in_ready` is low exactly when the entry slot holds an instruction that cannot move to the shared stage at the coming edge.
- R12: The load slot never holds a store, the store slot never holds a load and carries a zero count, and each taken load or store produces exactly one `done_ld` or `done_st` pulse, matching its kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is offered |
| in_is_store | input | 1 | Kind of the offered instruction: 1 store, 0 load |
| in_lat | input | LAT_W | Load-slot latency of the offered instruction |
| in_ready | output | 1 | The offered instruction is taken at the coming edge |
| pre_busy | output | 1 | Entry slot occupied |
| ls_busy | output | 1 | Shared memory stage occupied |
| ld_busy | output | 1 | Load slot occupied |
| st_busy | output | 1 | Store slot occupied |
| ld_remain | output | LAT_W | Remaining count of the load in the load slot |
| sb_state | output | 2 | Store-buffer fill state (0 empty, 1 partly filled, 2 full) |
| bus_free | output | 1 | Memory bus available for a load |
| done_ld | output | 1 | One-cycle pulse: a load retired |
| done_st | output | 1 | One-cycle pulse: a store retired |

## Verification
Every result is registered. An accepted instruction shows in `pre_busy` one rising edge after acceptance and in `ls_busy` one edge later. After a further edge it shows in `ld_busy` or `st_busy`, if not stalled. `ld_remain` changes once per edge, and the retire pulses and `sb_state` move on the same edge on which the instruction leaves its slot. `in_ready` and `bus_free` follow the present state in the same cycle. The bench advances its own reference state on each rising edge from the requirements alone. It compares every output at the falling edge that follows, so each comparison sees exactly one edge of progress. It sweeps every five-instruction mix of loads and stores over several latencies, with and without gaps in `in_valid`, and tallies retire pulses per kind.

// File: rtl/memq_pkg.sv
package memq_pkg;

   typedef enum logic [1:0] {
      SB_EMPTY = 2'd0,
      SB_PART  = 2'd1,
      SB_FULL  = 2'd2
   } sb_state_e;

   typedef enum logic {
      OP_LOAD  = 1'b0,
      OP_STORE = 1'b1
   } op_kind_e;

   localparam int unsigned KIND_CARRY     = 0;
   localparam int unsigned KIND_COUNTDOWN = 1;

endpackage

// File: rtl/memq_slot.sv
module memq_slot
   import memq_pkg::*;
#(
   parameter int unsigned LAT_W = 4,
   parameter int unsigned KIND  = KIND_CARRY
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             leave,
   input  logic             in_store,
   input  logic [LAT_W-1:0] in_lat,
   output logic             occ,
   output logic             is_store,
   output logic [LAT_W-1:0] cnt
);

   localparam logic [LAT_W-1:0] ONE = {{(LAT_W-1){1'b0}}, 1'b1};

   // occupancy and opcode are common to every variant
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         occ      <= 1'b0;
         is_store <= OP_LOAD;
      end else if (take) begin
         occ      <= 1'b1;
         is_store <= in_store;
      end else if (leave) begin
         occ      <= 1'b0;
      end
   end

   generate
      if (KIND == KIND_COUNTDOWN) begin : g_countdown
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (take) begin
               cnt <= in_lat;
            end else if (occ && (cnt != '0)) begin
               cnt <= cnt - ONE;
            end
         end
      end else begin : g_carry
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (take) begin
               cnt <= in_lat;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/memq_sbuf.sv
module memq_sbuf
   import memq_pkg::*;
#(
   parameter int unsigned DEPTH = 2,
   parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          bus_idle,
   output logic [CW-1:0] level,
   output logic [1:0]    state,
   output logic          full,
   output logic          empty,
   output logic          drain
);

   localparam logic [CW-1:0] LVL_FULL = CW'(DEPTH);
   localparam logic [CW-1:0] LVL_ONE  = {{(CW-1){1'b0}}, 1'b1};

   sb_state_e st_e;

   assign empty = (level == '0);
   assign full  = (level == LVL_FULL);
   assign drain = !empty && bus_idle;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level <= '0;
      end else begin
         unique case ({push, drain})
            2'b10:   level <= level + LVL_ONE;
            2'b01:   level <= level - LVL_ONE;
            default: level <= level;
         endcase
      end
   end

   always_comb begin
      if (empty)     st_e = SB_EMPTY;
      else if (full) st_e = SB_FULL;
      else           st_e = SB_PART;
   end

   assign state = st_e;

endmodule

// File: rtl/memq_ctrl.sv
module memq_ctrl #(
   parameter int unsigned LAT_W = 4
) (
   input  logic             pre_occ,
   input  logic             ls_occ,
   input  logic             ls_is_store,
   input  logic             ld_occ,
   input  logic [LAT_W-1:0] ld_cnt,
   input  logic             st_occ,
   input  logic             sb_empty,
   input  logic             sb_full,
   input  logic             sb_drain,
   output logic             bus_free,
   output logic             ld_leave,
   output logic             st_leave,
   output logic             ls_go,
   output logic             pre_go,
   output logic             entry_ready
);

   logic ls_to_ld;
   logic ls_to_st;

   assign bus_free = sb_empty && !st_occ;
   assign ld_leave = ld_occ && (ld_cnt == '0);
   // a store that finds the buffer full waits in the store slot unless it drains
   assign st_leave = st_occ && (!sb_full || sb_drain);

   assign ls_to_ld = !ls_is_store && bus_free && (!ld_occ || ld_leave);
   assign ls_to_st =  ls_is_store && !sb_full && (!st_occ || st_leave);
   assign ls_go    = ls_occ && (ls_to_ld || ls_to_st);

   assign pre_go      = pre_occ && (!ls_occ || ls_go);
   assign entry_ready = !pre_occ || pre_go;

endmodule

// File: rtl/memq_pipe.sv
module memq_pipe
   import memq_pkg::*;
#(
   parameter int unsigned LAT_W    = 4,
   parameter int unsigned SB_DEPTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_is_store,
   input  logic [LAT_W-1:0] in_lat,
   output logic             in_ready,
   output logic             pre_busy,
   output logic             ls_busy,
   output logic             ld_busy,
   output logic             st_busy,
   output logic [LAT_W-1:0] ld_remain,
   output logic [1:0]       sb_state,
   output logic             bus_free,
   output logic             done_ld,
   output logic             done_st
);

   localparam int unsigned SB_CW = $clog2(SB_DEPTH + 1);

   generate
      if (LAT_W < 1 || LAT_W > 16) begin : g_bad_lat
         $error("memq_pipe: LAT_W must lie in 1..16");
      end
      if (SB_DEPTH < 1 || SB_DEPTH > 64) begin : g_bad_depth
         $error("memq_pipe: SB_DEPTH must lie in 1..64");
      end
   endgenerate

   logic             pre_occ, pre_is_store;
   logic [LAT_W-1:0] pre_lat;
   logic             ls_occ, ls_is_store;
   logic [LAT_W-1:0] ls_lat;
   logic             ld_occ, ld_is_store;
   logic [LAT_W-1:0] ld_cnt;
   logic             st_occ, st_is_store;
   logic [LAT_W-1:0] st_cnt;
   logic [SB_CW-1:0] sb_level;
   logic             sb_full, sb_empty, sb_drain;
   logic             bus_ok, ld_leave, st_leave, ls_go, pre_go, entry_ready;
   logic             take_pre, take_ld, take_st;

   assign take_pre = in_valid && entry_ready;
   assign take_ld  = ls_go && !ls_is_store;
   assign take_st  = ls_go &&  ls_is_store;

   memq_ctrl #(.LAT_W(LAT_W)) u_ctrl (
      .pre_occ     (pre_occ),
      .ls_occ      (ls_occ),
      .ls_is_store (ls_is_store),
      .ld_occ      (ld_occ),
      .ld_cnt      (ld_cnt),
      .st_occ      (st_occ),
      .sb_empty    (sb_empty),
      .sb_full     (sb_full),
      .sb_drain    (sb_drain),
      .bus_free    (bus_ok),
      .ld_leave    (ld_leave),
      .st_leave    (st_leave),
      .ls_go       (ls_go),
      .pre_go      (pre_go),
      .entry_ready (entry_ready)
   );

   memq_slot #(.LAT_W(LAT_W), .KIND(KIND_CARRY)) u_pre (
      .clk(clk), .rst_n(rst_n), .take(take_pre), .leave(pre_go),
      .in_store(in_is_store), .in_lat(in_lat),
      .occ(pre_occ), .is_store(pre_is_store), .cnt(pre_lat)
   );

   memq_slot #(.LAT_W(LAT_W), .KIND(KIND_CARRY)) u_ls (
      .clk(clk), .rst_n(rst_n), .take(pre_go), .leave(ls_go),
      .in_store(pre_is_store), .in_lat(pre_lat),
      .occ(ls_occ), .is_store(ls_is_store), .cnt(ls_lat)
   );

   memq_slot #(.LAT_W(LAT_W), .KIND(KIND_COUNTDOWN)) u_ld (
      .clk(clk), .rst_n(rst_n), .take(take_ld), .leave(ld_leave),
      .in_store(ls_is_store), .in_lat(ls_lat),
      .occ(ld_occ), .is_store(ld_is_store), .cnt(ld_cnt)
   );

   // the store slot never carries a count: its entry value is forced to zero
   memq_slot #(.LAT_W(LAT_W), .KIND(KIND_CARRY)) u_st (
      .clk(clk), .rst_n(rst_n), .take(take_st), .leave(st_leave),
      .in_store(ls_is_store), .in_lat({LAT_W{1'b0}}),
      .occ(st_occ), .is_store(st_is_store), .cnt(st_cnt)
   );

   memq_sbuf #(.DEPTH(SB_DEPTH), .CW(SB_CW)) u_sbuf (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (st_leave),
      .bus_idle (!ld_occ),
      .level    (sb_level),
      .state    (sb_state),
      .full     (sb_full),
      .empty    (sb_empty),
      .drain    (sb_drain)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_ld <= 1'b0;
         done_st <= 1'b0;
      end else begin
         done_ld <= ld_leave;
         done_st <= st_leave;
      end
   end

   assign in_ready  = entry_ready;
   assign pre_busy  = pre_occ;
   assign ls_busy   = ls_occ;
   assign ld_busy   = ld_occ;
   assign st_busy   = st_occ;
   assign ld_remain = ld_cnt;
   assign bus_free  = bus_ok;

endmodule

// File: rtl/memq_pipe_chk.sv
module memq_pipe_chk #(
   parameter int unsigned LAT_W = 4,
   parameter int unsigned SB_CW = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ls_busy,
   input logic             ls_is_store,
   input logic             ld_busy,
   input logic             ld_is_store,
   input logic [LAT_W-1:0] ld_remain,
   input logic             st_busy,
   input logic             st_is_store,
   input logic [LAT_W-1:0] st_cnt,
   input logic [1:0]       sb_state,
   input logic [SB_CW-1:0] sb_level,
   input logic             bus_free,
   input logic             done_ld,
   input logic             done_st
);

   localparam logic [LAT_W-1:0] ONE = {{(LAT_W-1){1'b0}}, 1'b1};

   p_ld_no_store_r12: assert property (@(posedge clk) disable iff (!rst_n)
      ld_busy |-> !ld_is_store);

   p_st_no_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
      st_busy |-> st_is_store);

   p_st_zero_cnt_r12: assert property (@(posedge clk) disable iff (!rst_n)
      st_busy |-> (st_cnt == '0));

   p_countdown_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_busy && ld_remain != '0) |=> (ld_busy && ld_remain == $past(ld_remain) - ONE));

   p_ld_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_busy && ld_remain == '0) |=> done_ld);

   p_st_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_busy && sb_state != 2'd2) |=> done_st);

   p_state_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sb_state != 2'd3);

   p_empty_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sb_state == 2'd0) == (sb_level == '0));

   p_ld_needs_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ls_busy && !ls_is_store && !bus_free) |=> ls_busy);

   p_no_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_busy && !st_busy && sb_state != 2'd0) |=> $stable(sb_level));

   p_full_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (sb_state == 2'd2 && ls_busy && ls_is_store) |=> (ls_busy && ls_is_store));

endmodule

bind memq_pipe memq_pipe_chk #(.LAT_W(LAT_W), .SB_CW(SB_CW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ls_busy     (ls_occ),
   .ls_is_store (ls_is_store),
   .ld_busy     (ld_occ),
   .ld_is_store (ld_is_store),
   .ld_remain   (ld_cnt),
   .st_busy     (st_occ),
   .st_is_store (st_is_store),
   .st_cnt      (st_cnt),
   .sb_state    (sb_state),
   .sb_level    (sb_level),
   .bus_free    (bus_ok),
   .done_ld     (done_ld),
   .done_st     (done_st)
);

// File: tb/memq_pipe_tb.sv
module memq_pipe_tb;

   localparam int LW         = 4;
   localparam int DEP        = 2;
   localparam int CLK_PERIOD = 10;
   localparam int MAXN       = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_is_store = 1'b0;
   logic [LW-1:0] in_lat = '0;
   logic          in_ready, pre_busy, ls_busy, ld_busy, st_busy;
   logic [LW-1:0] ld_remain;
   logic [1:0]    sb_state;
   logic          bus_free, done_ld, done_st;

   always #(CLK_PERIOD / 2) clk = ~clk;

   memq_pipe #(.LAT_W(LW), .SB_DEPTH(DEP)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_is_store(in_is_store),
      .in_lat(in_lat), .in_ready(in_ready), .pre_busy(pre_busy), .ls_busy(ls_busy),
      .ld_busy(ld_busy), .st_busy(st_busy), .ld_remain(ld_remain),
      .sb_state(sb_state), .bus_free(bus_free), .done_ld(done_ld), .done_st(done_st)
   );

   int total = 0;
   int bad = 0;
   int cycles = 0;
   bit ended = 1'b0;

   // reference state, advanced at each rising edge from the requirements
   bit            m_pre, m_pre_s, m_ls, m_ls_s, m_ld, m_st, m_dl, m_ds;
   logic [LW-1:0] m_pre_l, m_ls_l, m_cnt;
   int            m_sb;
   bit            seq_s [MAXN];
   logic [LW-1:0] seq_l [MAXN];
   int            n_instr = 0;
   int            idx = 0;
   int            seen_ld, seen_st;

   function automatic bit f_bf();
      return (m_sb == 0) && !m_st;
   endfunction
   function automatic bit f_drain();
      return (m_sb != 0) && !m_ld;
   endfunction
   function automatic bit f_ldl();
      return m_ld && (m_cnt == 0);
   endfunction
   function automatic bit f_stl();
      return m_st && ((m_sb != DEP) || f_drain());
   endfunction
   function automatic bit f_lsgo();
      if (!m_ls) return 1'b0;
      if (m_ls_s) return (m_sb != DEP) && (!m_st || f_stl());
      return f_bf() && (!m_ld || f_ldl());
   endfunction
   function automatic bit f_rdy();
      return !m_pre || (!m_ls || f_lsgo());
   endfunction

   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         m_pre = 0; m_ls = 0; m_ld = 0; m_st = 0; m_dl = 0; m_ds = 0;
         m_pre_s = 0; m_ls_s = 0; m_pre_l = '0; m_ls_l = '0; m_cnt = '0; m_sb = 0;
      end else begin
         bit drn, ldl, stl, lsgo, prego, tk;
         drn   = f_drain();
         ldl   = f_ldl();
         stl   = f_stl();
         lsgo  = f_lsgo();
         prego = m_pre && (!m_ls || lsgo);
         tk    = in_valid && f_rdy();
         m_dl = ldl;
         m_ds = stl;
         m_sb = m_sb + (stl ? 1 : 0) - (drn ? 1 : 0);
         if (lsgo && !m_ls_s) begin m_ld = 1; m_cnt = m_ls_l; end
         else if (ldl) m_ld = 0;
         else if (m_ld && m_cnt != 0) m_cnt = m_cnt - 1'b1;
         if (lsgo && m_ls_s) m_st = 1;
         else if (stl) m_st = 0;
         if (prego) begin m_ls = 1; m_ls_s = m_pre_s; m_ls_l = m_pre_l; end
         else if (lsgo) m_ls = 0;
         if (tk) begin m_pre = 1; m_pre_s = in_is_store; m_pre_l = in_lat; idx++; end
         else if (prego) m_pre = 0;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
      end
   endtask

   task automatic compare_all();
      int exp_st;
      exp_st = (m_sb == 0) ? 0 : ((m_sb == DEP) ? 2 : 1);
      chk("R2 pre_busy", pre_busy, m_pre);
      chk("R8 ls_busy", ls_busy, m_ls);
      chk("R3 ld_busy", ld_busy, m_ld);
      chk("R10 st_busy", st_busy, m_st);
      chk("R4 ld_remain", ld_remain, m_cnt);
      chk((m_sb == DEP) ? "R6 sb_state full" : "R9 sb_state", sb_state, exp_st);
      chk("R7 bus_free", bus_free, f_bf());
      chk("R11 in_ready", in_ready, f_rdy());
      chk("R4 done_ld", done_ld, m_dl);
      chk("R5 done_st", done_st, m_ds);
      if (done_ld) seen_ld++;
      if (done_st) seen_st++;
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 190000);
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=0", cycles);
      finish_run();
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1: state under reset
      chk("R1 pre_busy", pre_busy, 0);
      chk("R1 ld_busy", ld_busy, 0);
      chk("R1 sb_state", sb_state, 0);
      chk("R1 bus_free", bus_free, 1);
      chk("R1 in_ready", in_ready, 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ls_busy", ls_busy, 0);
      chk("R1 st_busy", st_busy, 0);
      chk("R1 ld_remain", ld_remain, 0);
      chk("R1 done", {done_ld, done_st}, 0);

      for (int pat = 0; pat < (1 << MAXN); pat++) begin
         for (int li = 0; li < 4; li++) begin
            for (int gap = 0; gap < 2; gap++) begin
               int base, nld, nst, wait_c;
               base = (li == 3) ? 6 : li;
               nld = 0; nst = 0;
               for (int i = 0; i < MAXN; i++) begin
                  seq_s[i] = pat[i];
                  seq_l[i] = LW'((base + 2 * i) % 8);
                  if (pat[i]) nst++; else nld++;
               end
               n_instr = MAXN;
               idx = 0;
               seen_ld = 0; seen_st = 0;
               wait_c = 0;
               while ((idx < n_instr || m_pre || m_ls || m_ld || m_st || m_sb != 0 || m_dl || m_ds)
                      && wait_c < 400) begin
                  if (idx < n_instr && (gap == 0 || cycles[0])) begin
                     in_valid    = 1'b1;
                     in_is_store = seq_s[idx];
                     in_lat      = seq_l[idx];
                  end else begin
                     in_valid    = 1'b0;
                     in_is_store = 1'b0;
                     in_lat      = '0;
                  end
                  @(negedge clk);
                  compare_all();
                  wait_c++;
               end
               in_valid = 1'b0;
               @(negedge clk);
               compare_all();
               // R12: one retire pulse of the right kind per instruction
               chk("R12 loads retired", seen_ld, nld);
               chk("R12 stores retired", seen_st, nst);
            end
         end
      end
      finish_run();
   end

endmodule